// File: doc/BRIEF.md
# Pipelined binary-field inverter

This block returns the multiplicative inverse of an element of GF(2^n). The field is chosen per operation: the caller supplies the reducing polynomial and its degree n together with each operand. Every nonzero element has exactly one inverse, and the block produces it. A zero operand gives zero. Substitution steps of block ciphers depend on that convention, and it saves the caller from treating zero as a special case.

The inverse is formed as a^(2^n − 2). A fixed chain of stages computes it, and each stage squares the running power and, when the degree calls for it, folds that power into an accumulated product. There is one stage per possible squaring, so the unit accepts a new operand on every clock, and several inversions are in flight at once. The polynomial and degree travel down the pipeline beside their operand, so back-to-back operations may use different fields. Results leave in the order they arrived. When the consumer refuses a result, the whole pipeline holds.

Top module: `gf2n_inverter`

## Requirements
- R1: A zero operand (after masking, see R4) produces a zero result, for every degree including n = 1.
- R2: For a nonzero operand a, the result b satisfies a·b ≡ 1 modulo the supplied polynomial, and b < 2^n. With polynomial 0x11B and degree 8, the inverse of 0x53 is 0xCA.
- R3: Each operation uses the polynomial and degree presented with it. Operations in different fields may follow each other on consecutive cycles without affecting one another.
- R4: Operand bits at positions n and above are ignored. Bit i of in_poly is the coefficient of x^i, bit n must be 1, and the bits above n must be 0. The degree n is valid in the range 1..MAX_DEG.
- R5: After reset, out_valid is 0 and in_ready is 1. While out_ready stays high, an operand accepted at clock edge t is presented on out_elem with out_valid from edge t+MAX_DEG−2. One operand can be accepted per cycle, and results leave in acceptance order.
- R6: While out_valid is 1 and out_ready is 0, in_ready is 0, out_valid stays 1 and out_elem stays unchanged. No operation is lost or duplicated.
- R7: In degree 1 (polynomial 0x3), the inverse of 1 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand taken on this edge when in_valid is also high |
| in_elem | input | MAX_DEG | Element to invert |
| in_poly | input | MAX_DEG+1 | Reducing polynomial, bit i = coefficient of x^i |
| in_deg | input | $clog2(MAX_DEG+1) | Field degree n |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_elem | output | MAX_DEG | Inverse element |

## Verification
With no backpressure, each result is due exactly MAX_DEG−2 edges after the edge that accepted its operand: six edges at the default. The driver records the cycle count at the falling edge just before the accepting edge. The monitor, sampling at the falling edge after a result appears, requires a difference of MAX_DEG−1 in the phases where out_ready is held high. In the backpressure phase the latency check is switched off. There, the monitor compares results only on cycles where out_valid and out_ready are both high, and on every stalled cycle it confirms that the output held its value and that in_ready was low.

// File: rtl/gfi_pkg.sv
package gfi_pkg;
    // Number of square/multiply stages for a maximum degree w:
    // exponent 2^n - 2 needs squarings 1..n-1.
    function automatic int gfi_stage_count(input int w);
        return (w > 1) ? w - 1 : 1;
    endfunction
endpackage

// File: rtl/gfi_mul.sv
// Combinational GF(2^n) multiplier with runtime polynomial and degree.
module gfi_mul #(
    parameter int W  = 8,
    parameter int DW = $clog2(W + 1)
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    input  logic [W:0]    poly,
    input  logic [DW-1:0] deg,
    output logic [W-1:0]  prod
);
    logic [W:0] r;

    always_comb begin
        r = '0;
        for (int i = W - 1; i >= 0; i--) begin
            r = {r[W-1:0], 1'b0};
            if (r[deg]) r = r ^ poly;
            if (b[i]) r = r ^ {1'b0, a};
        end
        prod = r[W-1:0];
    end
endmodule

// File: rtl/gfi_stage.sv
// One pipeline step: square the running power and, if the exponent
// bit for this step lies below the degree, multiply it into the product.
module gfi_stage #(
    parameter int W  = 8,
    parameter int DW = $clog2(W + 1),
    parameter int K  = 1
) (
    input  logic [W-1:0]  pwr_in,
    input  logic [W-1:0]  acc_in,
    input  logic [W:0]    poly,
    input  logic [DW-1:0] deg,
    output logic [W-1:0]  pwr_out,
    output logic [W-1:0]  acc_out
);
    logic [W-1:0] sq;
    logic [W-1:0] prod;

    gfi_mul #(.W(W), .DW(DW)) u_sq (
        .a(pwr_in), .b(pwr_in), .poly(poly), .deg(deg), .prod(sq)
    );
    gfi_mul #(.W(W), .DW(DW)) u_mac (
        .a(acc_in), .b(sq), .poly(poly), .deg(deg), .prod(prod)
    );

    always_comb begin
        pwr_out = sq;
        acc_out = (deg > DW'(K)) ? prod : acc_in;
    end
endmodule

// File: rtl/gf2n_inverter.sv
module gf2n_inverter
    import gfi_pkg::*;
#(
    parameter int MAX_DEG = 8,
    localparam int W  = MAX_DEG,
    localparam int DW = $clog2(MAX_DEG + 1),
    localparam int L  = gfi_stage_count(MAX_DEG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [W-1:0]  in_elem,
    input  logic [W:0]    in_poly,
    input  logic [DW-1:0] in_deg,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_elem
);
    typedef struct packed {
        logic          vld;
        logic          zero;
        logic [W-1:0]  orig;
        logic [W-1:0]  pwr;
        logic [W-1:0]  acc;
        logic [W:0]    poly;
        logic [DW-1:0] deg;
    } stg_t;

    stg_t st_d [L];
    stg_t st_q [L];

    logic         stall;
    logic [W-1:0] in_mask;
    logic [W-1:0] a_in;

    logic [W-1:0]  src_pwr [L];
    logic [W-1:0]  src_acc [L];
    logic [W:0]    src_poly [L];
    logic [DW-1:0] src_deg [L];
    logic [W-1:0]  stg_pwr [L];
    logic [W-1:0]  stg_acc [L];

    always_comb begin
        for (int i = 0; i < W; i++) in_mask[i] = (DW'(i) < in_deg);
        a_in = in_elem & in_mask;
    end

    for (genvar s = 0; s < L; s++) begin : g_stage
        if (s == 0) begin : g_head
            assign src_pwr[s]  = a_in;
            assign src_acc[s]  = W'(1);
            assign src_poly[s] = in_poly;
            assign src_deg[s]  = in_deg;
        end else begin : g_body
            assign src_pwr[s]  = st_q[s-1].pwr;
            assign src_acc[s]  = st_q[s-1].acc;
            assign src_poly[s] = st_q[s-1].poly;
            assign src_deg[s]  = st_q[s-1].deg;
        end
        gfi_stage #(.W(W), .DW(DW), .K(s + 1)) u_stage (
            .pwr_in (src_pwr[s]),
            .acc_in (src_acc[s]),
            .poly   (src_poly[s]),
            .deg    (src_deg[s]),
            .pwr_out(stg_pwr[s]),
            .acc_out(stg_acc[s])
        );
    end

    assign stall     = st_q[L-1].vld && !out_ready;
    assign in_ready  = !stall;
    assign out_valid = st_q[L-1].vld;
    assign out_elem  = st_q[L-1].zero ? '0 : st_q[L-1].acc;

    always_comb begin
        st_d = st_q;
        if (!stall) begin
            st_d[0].vld  = in_valid;
            st_d[0].zero = (a_in == '0);
            st_d[0].orig = a_in;
            st_d[0].pwr  = stg_pwr[0];
            st_d[0].acc  = stg_acc[0];
            st_d[0].poly = in_poly;
            st_d[0].deg  = in_deg;
            for (int s = 1; s < L; s++) begin
                st_d[s]     = st_q[s-1];
                st_d[s].pwr = stg_pwr[s];
                st_d[s].acc = stg_acc[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{default: '0};
        else        st_q <= st_d;
    end

    // Independent product check of the leaving result against its operand
    logic [W-1:0] chk_prod;
    gfi_mul #(.W(W), .DW(DW)) u_chk (
        .a(st_q[L-1].orig), .b(out_elem), .poly(st_q[L-1].poly),
        .deg(st_q[L-1].deg), .prod(chk_prod)
    );

    assert_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q[L-1].orig != '0) |-> (chk_prod == W'(1)));

    assert_zero_in_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && st_q[L-1].orig == '0) |-> (out_elem == '0));

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_elem)));

    assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> st_q[0].vld);

    for (genvar s = 1; s < L; s++) begin : g_adv
        assert_advance_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[s-1].vld && in_ready) |=> st_q[s].vld);
    end
endmodule

// File: tb/tb_gf2n_inverter.sv
`timescale 1ns/1ps
module tb_gf2n_inverter;
    localparam int W  = 8;
    localparam int DW = $clog2(W + 1);
    localparam int LAT = W - 1; // negedge-to-negedge count, no stall

    logic          clk = 0;
    logic          rst_n = 0;
    logic          in_valid = 0;
    logic          in_ready;
    logic [W-1:0]  in_elem = '0;
    logic [W:0]    in_poly = '0;
    logic [DW-1:0] in_deg = '0;
    logic          out_valid;
    logic          out_ready = 1;
    logic [W-1:0]  out_elem;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit bp_mode = 0;
    bit lat_chk = 1;
    bit done = 0;

    logic [W-1:0] exp_q [$];
    string        tag_q [$];
    int           cyc_q [$];

    gf2n_inverter #(.MAX_DEG(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_elem(in_elem), .in_poly(in_poly), .in_deg(in_deg),
        .out_valid(out_valid), .out_ready(out_ready), .out_elem(out_elem)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #2;
        out_ready = bp_mode ? ($urandom % 3 != 0) : 1'b1;
    end

    // Reference: plain polynomial product then long-division remainder
    function automatic logic [7:0] ref_mul(logic [7:0] a, logic [7:0] b,
                                           logic [8:0] poly, int n);
        logic [15:0] t = '0;
        for (int i = 0; i < 8; i++) if (b[i]) t = t ^ (16'(a) << i);
        for (int i = 15; i >= n; i--) if (t[i]) t = t ^ (16'(poly) << (i - n));
        return t[7:0];
    endfunction

    function automatic logic [7:0] ref_inv(logic [7:0] a, logic [8:0] poly, int n);
        if (a == 0) return 8'h00;
        for (int b = 1; b < (1 << n); b++)
            if (ref_mul(a, 8'(b), poly, n) == 8'h01) return 8'(b);
        return 8'h00;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_exp(logic [7:0] e, logic [8:0] p, int n,
                            logic [7:0] expv, string tag);
        @(negedge clk);
        in_valid = 1; in_elem = e; in_poly = p; in_deg = DW'(n);
        while (!in_ready) @(negedge clk);
        exp_q.push_back(expv); tag_q.push_back(tag); cyc_q.push_back(cyc);
    endtask

    task automatic send(logic [7:0] e, logic [8:0] p, int n, string tag);
        logic [7:0] a;
        a = e & 8'((1 << n) - 1);
        send_exp(e, p, n, ref_inv(a, p, n), tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    // Scoreboard monitor
    bit held_v = 0;
    logic [W-1:0] held_e;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (held_v) begin
                check(out_valid && out_elem == held_e, "R6 hold",
                      int'(out_elem), int'(held_e));
                held_v = 0;
            end
            if (out_valid && !out_ready) begin
                check(!in_ready, "R6 in_ready low in stall", int'(in_ready), 0);
                held_v = 1; held_e = out_elem;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5 unexpected result", int'(out_elem), 0);
                end else begin
                    logic [W-1:0] e;
                    string t;
                    int c;
                    e = exp_q.pop_front(); t = tag_q.pop_front(); c = cyc_q.pop_front();
                    check(out_elem == e, t, int'(out_elem), int'(e));
                    if (lat_chk) check(cyc - c == LAT, "R5 latency", cyc - c, LAT);
                end
            end
        end
    end

    task automatic finish_up();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    task automatic drain();
        int t = 0;
        while (exp_q.size() != 0 && t < 2000) begin @(negedge clk); t++; end
        check(exp_q.size() == 0, "R5 drain", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 0, "R5 reset out_valid", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        check(out_valid == 0, "R5 out_valid after reset", int'(out_valid), 0);
        check(in_ready == 1, "R5 in_ready after reset", int'(in_ready), 1);

        // Fixed known value, zero in several fields
        send_exp(8'h53, 9'h11B, 8, 8'hCA, "R2 0x53->0xCA");
        send_exp(8'h00, 9'h11B, 8, 8'h00, "R1 zero deg8");
        send_exp(8'h00, 9'h003, 1, 8'h00, "R1 zero deg1");
        send_exp(8'h01, 9'h003, 1, 8'h01, "R7 one deg1");
        // Whole field, back to back
        for (int x = 1; x < 256; x++) send(8'(x), 9'h11B, 8, "R2 all deg8");
        // Interleaved fields every cycle
        for (int x = 1; x < 8; x++) begin
            send(8'(x), 9'h11B, 8, "R3 mix deg8");
            send(8'(x), 9'h013, 4, "R3 mix deg4");
            send(8'(x), 9'h00B, 3, "R3 mix deg3");
            send(8'(x), 9'h003, 1, "R3 mix deg1");
        end
        // Upper operand bits ignored
        send(8'hF3, 9'h013, 4, "R4 high bits masked");
        send(8'hF0, 9'h013, 4, "R4 masked to zero");
        send(8'h1A, 9'h00B, 3, "R4 high bits masked deg3");
        idle();
        drain();

        // Backpressure phase
        lat_chk = 0;
        bp_mode = 1;
        for (int x = 0; x < 64; x++) begin
            send(8'(x * 7 + 3), 9'h11B, 8, "R6 backpressure deg8");
            send(8'(x), 9'h013, 4, "R6 backpressure deg4");
        end
        idle();
        drain();
        bp_mode = 0;
        repeat (4) @(negedge clk);
        check(out_valid == 0, "R5 idle after drain", int'(out_valid), 0);
        finish_up();
    end
endmodule